// File: doc/BRIEF.md
# I2C Serial Memory Read Slave

This block is the bus-facing half of a small byte-wide serial memory. It watches a two-wire bus (SCL, SDA), decodes START, STOP and repeated START, matches a 7-bit device identifier plus a read/write bit, and serves reads out of a 16-byte array through an internal address pointer. A write that carries only an address byte sets the pointer. If a repeated START and a read request follow, the result is a random read. If a STOP follows instead, the pointer is set and nothing is read. A read request with no address phase returns the byte at the current pointer. Each byte that the master acknowledges is followed by the next byte, so reads run sequentially.

Two further identifiers select auxiliary register spaces. Their registers are a stub here: writes are acknowledged and discarded, and reads return zero. Any access to them arms a lock. While the lock is armed, a read with no address phase is refused, until a full random read of the array clears it. SDA is open-drain: the block only ever pulls the line low and reports this on `sda_oe`. Both bus inputs are synchronised to `clk`, which must run well above the SCL rate.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset, SDA is released, the pointer is 0 and the auxiliary lock is clear, so a first read with no address phase returns the byte at address 0.
- R2: Identifier 1010000 selects the array, and 1010111 and 1010010 select the auxiliary space; all three are acknowledged. Any other identifier is not acknowledged, and the block then ignores the bus until the next START.
- R3: A random read is a write holding one address byte, then a repeated START and a read request. The address byte loads the pointer from its low 4 bits, and the read returns the byte at that address.
- R4: Array byte a holds (a*0x3B + 0x5C) mod 256. Reads from the auxiliary space return 0x00.
- R5: A STOP right after the address byte loads the pointer without a read. Clocks and data seen before the next START are ignored, and SDA stays released.
- R6: During a read, the pointer advances after each byte is sent and wraps from 15 to 0. Each byte the master acknowledges is followed by the next one. A non-acknowledge ends the read.
- R7: After any auxiliary access, a read with no address phase is not acknowledged. A random read of the array removes this restriction.
- R8: A read request with no address phase returns the byte at the current pointer.
- R9: In a write to the array, a data byte after the address byte is not acknowledged. Data bytes written to the auxiliary space are acknowledged.
- R10: A START inside a byte restarts identifier decoding. A STOP inside a byte returns to idle and leaves the pointer unchanged.
- R11: SDA is pulled low only for acknowledge bits and for zero data bits. It is sent MSB first and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock as seen on the pin |
| sda_in | input | 1 | Bus data as seen on the pin (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Every response of the slave is due a few `clk` cycles after the SCL falling edge that ends the previous bit. The delay is two synchroniser stages, one edge-detect stage and the output register, about four cycles in all. The bench holds SCL low for ten cycles before raising it and samples SDA in the middle of the high phase, so each acknowledge and data bit has settled by then. Pointer updates cannot be seen directly. They are checked on a later read, whose first byte must match the pointer value worked out from the requirements.

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
  parameter int DEPTH = 16,
  parameter logic [6:0] ARR_ID = 7'b1010000,
  parameter logic [6:0] AUX_ID_A = 7'b1010111,
  parameter logic [6:0] AUX_ID_B = 7'b1010010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_DEVACK, S_WADR, S_WDAT, S_WACK, S_TX, S_MACK
  } st_t;

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    logic [7:0] w;
    w = 8'(a);
    return 8'(w * 8'h3B + 8'h5C);
  endfunction

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [AW-1:0] ptr;
  logic drive, is_rd, aux_sel, aux_lock, have_adr, macked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire bus_start = scl_s & scl_p & sda_p & ~sda_s;
  wire bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  wire [6:0] id  = sh[7:1];
  wire       rw  = sh[0];
  wire hit_arr = (id == ARR_ID);
  wire hit_aux = (id == AUX_ID_A) || (id == AUX_ID_B);
  wire dev_ok  = hit_aux | (hit_arr & (~rw | have_adr | ~aux_lock));
  wire byte_in = (cnt == 4'd8);

  wire [7:0]    next_byte = aux_sel ? 8'h00 : rom_byte(ptr);
  wire [AW-1:0] ptr_inc   = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  assign sda_oe = drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      drive    <= 1'b0;
      is_rd    <= 1'b0;
      aux_sel  <= 1'b0;
      aux_lock <= 1'b0;
      have_adr <= 1'b0;
      macked   <= 1'b0;
    end else if (bus_start) begin
      st    <= S_DEV;
      cnt   <= '0;
      drive <= 1'b0;
    end else if (bus_stop) begin
      st       <= S_IDLE;
      drive    <= 1'b0;
      have_adr <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && byte_in) begin
            if (st == S_DEV) begin
              have_adr <= 1'b0;
              if (dev_ok) begin
                st      <= S_DEVACK;
                drive   <= 1'b1;
                is_rd   <= rw;
                aux_sel <= hit_aux;
                if (hit_aux)
                  aux_lock <= 1'b1;
                else if (rw && have_adr)
                  aux_lock <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_WADR) begin
              if (!aux_sel) begin
                ptr      <= sh[AW-1:0];
                have_adr <= 1'b1;
              end
              drive <= 1'b1;
              st    <= S_WACK;
            end else begin
              if (aux_sel) begin
                drive <= 1'b1;
                st    <= S_WACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        S_DEVACK: begin
          if (scl_fall) begin
            if (is_rd) begin
              sh    <= next_byte;
              drive <= ~next_byte[7];
              cnt   <= 4'd1;
              st    <= S_TX;
            end else begin
              drive <= 1'b0;
              cnt   <= '0;
              st    <= S_WADR;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            drive <= 1'b0;
            cnt   <= '0;
            st    <= S_WDAT;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (byte_in) begin
              drive <= 1'b0;
              st    <= S_MACK;
              if (!aux_sel) ptr <= ptr_inc;
            end else begin
              sh    <= {sh[6:0], 1'b0};
              drive <= ~sh[6];
              cnt   <= cnt + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            macked <= ~sda_s;
          end else if (scl_fall) begin
            if (macked) begin
              sh    <= next_byte;
              drive <= ~next_byte[7];
              cnt   <= 4'd1;
              st    <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_reader_chk.sv
module i2c_mem_reader_chk #(
  parameter int AW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic aux_lock,
  input logic [AW-1:0] ptr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sda_oe && !aux_lock));

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R6
  ptr_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> !scl_in);

  // R7
  lock_set_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_lock) |-> sda_oe);

  // R7
  lock_clr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_lock) |-> sda_oe);
endmodule

bind i2c_mem_reader i2c_mem_reader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .aux_lock(aux_lock), .ptr(ptr)
);

// File: tb/sim_i2c_mem_reader.sv
module sim_i2c_mem_reader;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_mem_reader u0 (.clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe));

  int nchk = 0, nerr = 0, mptr = 0;
  int exp_q[$];
  int got_q[$];
  string tag_q[$];
  logic watch = 1'b0, oe_seen = 1'b0;

  function automatic int rom(int a);
    return (a * 59 + 92) & 255;
  endfunction

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      int g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, g, e);
    end
  end

  always @(posedge clk) if (watch && sda_oe) oe_seen = 1'b1;

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1; wt(H); m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; wt(2);
  endtask

  task automatic bstop();
    m_sda = 0; wt(H); m_scl = 1; wt(H); m_sda = 1; wt(H);
  endtask

  task automatic tx_bit(bit b);
    m_sda = b; wt(H); m_scl = 1; wt(H); m_scl = 0; wt(2);
  endtask

  task automatic rx_bit(output bit b);
    m_sda = 1; wt(H); m_scl = 1; wt(H / 2); b = sda_bus; wt(H / 2); m_scl = 0; wt(2);
  endtask

  task automatic wr_byte(logic [7:0] v, string tag, int exp_ack);
    bit b;
    exp_q.push_back(exp_ack); tag_q.push_back({tag, " ack"});
    for (int i = 7; i >= 0; i--) tx_bit(v[i]);
    rx_bit(b);
    got_q.push_back(b ? 0 : 1);
  endtask

  task automatic rd_byte(string tag, int exp, bit ack);
    bit b;
    logic [7:0] v;
    exp_q.push_back(exp); tag_q.push_back({tag, " data"});
    for (int i = 7; i >= 0; i--) begin rx_bit(b); v[i] = b; end
    tx_bit(!ack);
    got_q.push_back(int'(v));
  endtask

  task automatic rd_run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      rd_byte(tag, rom(mptr), i < n - 1);
      mptr = (mptr + 1) % 16;
    end
  endtask

  task automatic cur_read(int n, string tag);
    bstart(); wr_byte(8'hA1, tag, 1); rd_run(n, tag); bstop();
  endtask

  task automatic rnd_read(int a, int n, string tag);
    bstart(); wr_byte(8'hA0, tag, 1); wr_byte(8'(a), tag, 1); mptr = a % 16;
    bstart(); wr_byte(8'hA1, tag, 1); rd_run(n, tag); bstop();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    wt(5); rst_n = 1; wt(4);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    cur_read(1, "R1 R8 first read");
    rnd_read(5, 1, "R3 R4 R11 random");
    cur_read(1, "R8 current");
    rnd_read(8'h2E, 3, "R6 sequential wrap");
    // R5 set current address, then bus noise without START
    bstart(); wr_byte(8'hA0, "R5", 1); wr_byte(8'h09, "R5", 1); bstop(); mptr = 9;
    oe_seen = 0; watch = 1;
    m_scl = 0; wt(H);
    for (int i = 0; i < 9; i++) tx_bit(i[0]);
    m_sda = 1; wt(H); m_scl = 1; wt(H);
    watch = 0;
    chk("R5 standby ignores bus", int'(oe_seen), 0);
    cur_read(1, "R5 pointer set");
    // R2 unknown identifier, and idle until START
    bstart(); wr_byte(8'h90, "R2 bad id", 0); wr_byte(8'hA1, "R2 no START", 0); bstop();
    // R7 auxiliary access arms the lock
    bstart(); wr_byte(8'hAE, "R2 aux id", 1); wr_byte(8'h33, "R9 aux addr", 1);
    wr_byte(8'h44, "R9 aux data", 1); bstop();
    bstart(); wr_byte(8'hA1, "R7 blocked", 0); bstop();
    bstart(); wr_byte(8'hA5, "R2 aux id2", 1); rd_byte("R4 aux zero", 0, 0); bstop();
    rnd_read(3, 2, "R7 random unlocks");
    cur_read(1, "R7 current after unlock");
    // R9 array data byte refused
    bstart(); wr_byte(8'hA0, "R9", 1); wr_byte(8'h02, "R9", 1); mptr = 2;
    wr_byte(8'h55, "R9 array data", 0); bstop();
    cur_read(1, "R9 pointer kept");
    // R10 START inside a byte
    bstart(); tx_bit(1); tx_bit(0); tx_bit(1); tx_bit(0);
    bstart(); wr_byte(8'hA1, "R10 restart", 1); rd_run(1, "R10 restart"); bstop();
    // R10 STOP inside a byte
    bstart(); wr_byte(8'hA0, "R10 stop", 1); tx_bit(1); tx_bit(1); tx_bit(1); bstop();
    cur_read(1, "R10 pointer unchanged");
    wt(20);
    chk("R1 scoreboard drained", got_q.size() + exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule